// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer

This block sends one command to a memory card running in SPI mode and returns the card's one-byte status reply. A caller gives a 6-bit command index, a 32-bit argument, a 7-bit checksum field and a hold option, all qualified by a one-cycle request strobe. The block pulls chip select low and sends a six-byte frame through an external byte-wide SPI shifter. It then clocks out filler bytes until the card answers or until a poll budget runs out. The outcome is reported with a one-cycle `done` pulse.

The shifter has a simple handshake. The block pulses `xfer_start` with a byte on `xfer_tx`. The shifter later pulses `xfer_valid` with the byte it received during that same transfer. There is only ever one transfer in flight. In normal mode the block raises chip select after the status and clocks one more idle byte before `done`. In hold mode a good reply leaves chip select low, so that the caller can go on to collect trailing reply bytes.

Top module: `sd_cmd_issuer`

## Requirements
- R1: The frame is six bytes, sent in this order: `{2'b01, index[5:0]}`, then arg[31:24], arg[23:16], arg[15:8], arg[7:0], and last `{crc[6:0], 1'b1}`. For example, a crc field of 7'h4A gives the byte 0x95.
- R2: `cs_n` goes low when a request is accepted, one cycle before the first frame byte starts. It stays low through the frame and through every poll byte.
- R3: After the frame, each poll transfer sends 0xFF. The first received poll byte whose bit 7 is 0 becomes `resp_status`. Bytes received while the frame is being sent are ignored, whatever their value.
- R4: If POLL_LIMIT poll bytes (5000 by default) all arrive with bit 7 set, the command ends with `resp_timeout`=1. A valid reply in the POLL_LIMIT-th poll byte is still accepted.
- R5: In normal mode, after a reply or a timeout, `cs_n` rises. Exactly one further 0xFF transfer is then made with `cs_n` high, and after it `done` pulses.
- R6: In hold mode, a valid reply leaves `cs_n` low and no trailing transfer is made. A timeout in hold mode releases `cs_n` and makes the trailing transfer, exactly as in normal mode.
- R7: `done` is high for exactly one cycle. `resp_status` and `resp_timeout` stay stable from `done` until the next request is accepted. On a timeout, `resp_status` reads 0xFF.
- R8: A request strobe that arrives while a command is in progress is ignored. It changes no frame byte and starts no second command.
- R9: After reset, `cs_n`=1, `done`=0, `xfer_start`=0 and `resp_timeout`=0.
- R10: `xfer_start` is a one-cycle pulse. No new transfer starts before `xfer_valid` has returned for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_crc | input | 7 | Checksum field placed above the end bit |
| req_hold | input | 1 | Keep chip select low after a valid reply |
| done | output | 1 | One-cycle completion pulse |
| resp_status | output | 8 | Status byte received from the card |
| resp_timeout | output | 1 | No reply within the poll budget |
| cs_n | output | 1 | Card chip select, active low |
| xfer_start | output | 1 | Starts one byte transfer |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_valid | input | 1 | Transfer finished, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received during the transfer |

## Verification
Each table vector differs in command index, argument pattern, checksum field, number of busy poll bytes before the reply, and mode, so that every frame byte position and both chip-select endings are covered.

Every frame byte is answered with 0x00. A design that looked for the reply too early would therefore take a frame-time byte as the status. The busy poll bytes carry varied values with bit 7 set, which separates a bit-7 test from an all-ones test.

Directed runs check three boundary cases:
- a reply in the very last allowed poll byte against one poll too late;
- a timeout in hold mode;
- a request strobe raised in the middle of a command.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int POLL_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [5:0]  req_index,
  input  logic [31:0] req_arg,
  input  logic [6:0]  req_crc,
  input  logic        req_hold,
  output logic        done,
  output logic [7:0]  resp_status,
  output logic        resp_timeout,
  output logic        cs_n,
  output logic        xfer_start,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_valid,
  input  logic [7:0]  xfer_rx
);

  localparam int CW       = $clog2(POLL_LIMIT + 1);
  localparam int LAST_IDX = 5;
  localparam logic [7:0] FILL = 8'hFF;

  typedef enum logic [2:0] {ST_IDLE, ST_FRAME, ST_POLL, ST_TAIL, ST_DONE} st_t;

  st_t          st_q;
  logic [2:0]   idx_q;
  logic [CW-1:0] poll_q;
  logic         pend_q;
  logic         hold_q;
  logic [5:0]   index_q;
  logic [31:0]  arg_q;
  logic [6:0]   crc_q;
  logic [7:0]   status_q;
  logic         tmo_q;
  logic         cs_q;
  logic         start_q;
  logic [7:0]   tx_q;
  logic [7:0]   frame_byte;

  wire got_byte  = pend_q && xfer_valid;
  wire need_xfer = !pend_q && (st_q == ST_FRAME || st_q == ST_POLL || st_q == ST_TAIL);
  wire last_poll = (poll_q == CW'(POLL_LIMIT - 1));

  always_comb begin
    case (idx_q)
      3'd0:    frame_byte = {2'b01, index_q};
      3'd1:    frame_byte = arg_q[31:24];
      3'd2:    frame_byte = arg_q[23:16];
      3'd3:    frame_byte = arg_q[15:8];
      3'd4:    frame_byte = arg_q[7:0];
      3'd5:    frame_byte = {crc_q, 1'b1};
      default: frame_byte = FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      poll_q   <= '0;
      pend_q   <= 1'b0;
      hold_q   <= 1'b0;
      index_q  <= '0;
      arg_q    <= '0;
      crc_q    <= '0;
      status_q <= FILL;
      tmo_q    <= 1'b0;
      cs_q     <= 1'b1;
      start_q  <= 1'b0;
      tx_q     <= FILL;
    end else begin
      start_q <= 1'b0;
      if (need_xfer) begin
        start_q <= 1'b1;
        pend_q  <= 1'b1;
        tx_q    <= (st_q == ST_FRAME) ? frame_byte : FILL;
      end
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            index_q <= req_index;
            arg_q   <= req_arg;
            crc_q   <= req_crc;
            hold_q  <= req_hold;
            idx_q   <= '0;
            cs_q    <= 1'b0;
            st_q    <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (got_byte) begin
            pend_q <= 1'b0;
            if (idx_q == 3'(LAST_IDX)) begin
              poll_q <= '0;
              st_q   <= ST_POLL;
            end else begin
              idx_q <= idx_q + 3'd1;
            end
          end
        end
        ST_POLL: begin
          if (got_byte) begin
            pend_q <= 1'b0;
            if (!xfer_rx[7]) begin
              status_q <= xfer_rx;
              tmo_q    <= 1'b0;
              if (hold_q) begin
                st_q <= ST_DONE;
              end else begin
                cs_q <= 1'b1;
                st_q <= ST_TAIL;
              end
            end else if (last_poll) begin
              status_q <= FILL;
              tmo_q    <= 1'b1;
              cs_q     <= 1'b1;
              st_q     <= ST_TAIL;
            end else begin
              poll_q <= poll_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (got_byte) begin
            pend_q <= 1'b0;
            st_q   <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done         = (st_q == ST_DONE);
  assign resp_status  = status_q;
  assign resp_timeout = tmo_q;
  assign cs_n         = cs_q;
  assign xfer_start   = start_q;
  assign xfer_tx      = tx_q;

endmodule

module sd_cmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       xfer_start,
  input logic       xfer_valid,
  input logic       done,
  input logic       resp_timeout,
  input logic [7:0] resp_status
);

  logic inflight_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          inflight_q <= 1'b0;
    else if (xfer_start) inflight_q <= 1'b1;
    else if (xfer_valid) inflight_q <= 1'b0;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_one_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !inflight_q);

  assert_cs_before_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !xfer_start);

  assert_timeout_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp_timeout) |-> cs_n);

  assert_status_bit7_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !resp_timeout) |-> !resp_status[7]);

  assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(resp_status) && $stable(resp_timeout)));

endmodule

bind sd_cmd_issuer sd_cmd_issuer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .xfer_start(xfer_start),
  .xfer_valid(xfer_valid), .done(done), .resp_timeout(resp_timeout),
  .resp_status(resp_status)
);

// File: tb/sd_cmd_issuer_tb.sv
module sd_cmd_issuer_tb_top;
  localparam int LIMIT = 5000;
  localparam int NV    = 6;

  localparam logic [5:0]  V_IDX [NV] = '{6'd0, 6'd8, 6'd55, 6'd17, 6'd58, 6'd41};
  localparam logic [31:0] V_ARG [NV] = '{32'h0, 32'h000001AA, 32'h0, 32'h00012400, 32'hA5C30F81, 32'h40000000};
  localparam logic [6:0]  V_CRC [NV] = '{7'h4A, 7'h43, 7'h4A, 7'h7F, 7'h00, 7'h12};
  localparam logic        V_HLD [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_BSY [NV] = '{0, 3, 1, 2, 0, 7};
  localparam logic [7:0]  V_STA [NV] = '{8'h01, 8'h05, 8'h00, 8'h00, 8'h7F, 8'h40};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_hold = 0;
  logic [5:0] req_index = 0;
  logic [31:0] req_arg = 0;
  logic [6:0] req_crc = 0;
  logic done, resp_timeout, cs_n, xfer_start;
  logic [7:0] resp_status, xfer_tx;
  logic xfer_valid = 0;
  logic [7:0] xfer_rx = 0;

  int checks = 0, errors = 0;
  int k, busy_n, lo_starts, hi_starts, done_cnt;
  logic [7:0] reply_b, last_tx;
  logic [7:0] tx_log [6];

  always #4 clk = ~clk;

  sd_cmd_issuer #(.POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .req_arg(req_arg), .req_crc(req_crc), .req_hold(req_hold), .done(done),
    .resp_status(resp_status), .resp_timeout(resp_timeout), .cs_n(cs_n),
    .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_valid(xfer_valid),
    .xfer_rx(xfer_rx));

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      xfer_valid = 0;
      if (done) done_cnt++;
      if (xfer_start) begin
        if (k < 6) tx_log[k] = xfer_tx;
        last_tx = xfer_tx;
        if (cs_n) hi_starts++; else lo_starts++;
        @(negedge clk);
        if (done) done_cnt++;
        if (k < 6)                xfer_rx = 8'h00;
        else if (k - 6 < busy_n)  xfer_rx = 8'h80 | 8'((k - 6) % 128);
        else if (k - 6 == busy_n) xfer_rx = reply_b;
        else                      xfer_rx = 8'hFF;
        xfer_valid = 1;
        k++;
      end
    end
  end

  task automatic run(input logic [5:0] ix, input logic [31:0] ag, input logic [6:0] cr,
                     input logic hd, input int bz, input logic [7:0] st, input bit inject);
    logic [7:0] exp_f [6];
    bit tmo;
    int core;
    exp_f[0] = {2'b01, ix}; exp_f[1] = ag[31:24]; exp_f[2] = ag[23:16];
    exp_f[3] = ag[15:8];    exp_f[4] = ag[7:0];   exp_f[5] = {cr, 1'b1};
    tmo = (bz >= LIMIT);
    core = tmo ? 6 + LIMIT : 6 + bz + 1;
    k = 0; busy_n = bz; reply_b = st; lo_starts = 0; hi_starts = 0; done_cnt = 0;
    @(negedge clk);
    req_index = ix; req_arg = ag; req_crc = cr; req_hold = hd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(cs_n == 0 && xfer_start == 0, "R2 cs low before first byte", {cs_n, xfer_start}, 0);
    fork
      begin
        while (!done) @(negedge clk);
      end
      begin
        if (inject) begin
          repeat (8) @(negedge clk);
          req_index = 6'h3F; req_arg = 32'hFFFF_FFFF; req_crc = 7'h00; req_hold = 1; req_valid = 1;
          @(negedge clk);
          req_valid = 0;
        end
      end
    join
    for (int i = 0; i < 6; i++)
      chk(tx_log[i] == exp_f[i], "R1 frame byte", tx_log[i], exp_f[i]);
    chk(resp_timeout == tmo, "R4 timeout flag", resp_timeout, tmo);
    if (!tmo) chk(resp_status == st, "R3 status byte", resp_status, st);
    else      chk(resp_status == 8'hFF, "R7 status on timeout", resp_status, 8'hFF);
    chk(lo_starts == core, "R2 R3 transfers with cs low", lo_starts, core);
    if (hd && !tmo) begin
      chk(hi_starts == 0, "R6 no trailing byte in hold", hi_starts, 0);
      chk(cs_n == 0, "R6 cs held low", cs_n, 0);
    end else begin
      chk(hi_starts == 1 && last_tx == 8'hFF, "R5 R6 one trailing FF with cs high", {hi_starts[7:0], last_tx}, 16'h01FF);
      chk(cs_n == 1, "R5 cs released", cs_n, 1);
    end
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
    repeat (12) @(negedge clk);
    chk(done_cnt == 1 && xfer_start == 0, "R8 single completion, no extra command", done_cnt, 1);
    chk(resp_timeout == tmo && (tmo || resp_status == st), "R7 result held", {resp_timeout, resp_status}, {tmo, st});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    k = 0; busy_n = 0; reply_b = 0; done_cnt = 0; lo_starts = 0; hi_starts = 0; last_tx = 0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && done == 0 && xfer_start == 0 && resp_timeout == 0, "R9 reset state",
        {cs_n, done, xfer_start, resp_timeout}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && xfer_start == 0, "R9 idle after reset", {cs_n, xfer_start}, 2'b10);
    for (int v = 0; v < NV; v++)
      run(V_IDX[v], V_ARG[v], V_CRC[v], V_HLD[v], V_BSY[v], V_STA[v], 0);
    // R4 reply in the last allowed poll byte
    run(6'd16, 32'h00000200, 7'h0A, 0, LIMIT - 1, 8'h00, 0);
    // R4 R5 timeout in normal mode
    run(6'd9, 32'h0, 7'h4A, 0, LIMIT, 8'h00, 0);
    // R6 timeout in hold mode releases cs
    run(6'd24, 32'h1234_5678, 7'h55, 1, LIMIT, 8'h00, 0);
    // R8 request during a busy command
    run(6'd13, 32'hCAFE_0042, 7'h21, 0, 4, 8'h02, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule